// File: doc/BRIEF.md
# Endpoint Handshake Response Selector

This block decides, for each token a host sends to one of a set of endpoint pipes, which handshake the device returns: NAK, ACK, NYET, STALL, or a data packet for an IN token. Software sets a two-bit response code per pipe. The block combines that code with the buffer state reported for the addressed pipe and with a per-pipe flag that turns off the NYET reply.

The block also owns the DATA0/DATA1 sequence bit of every pipe. It reports the bit with each response, flips it after every successful transaction, and clears it on command. For OUT data it compares the received length against the pipe's maximum packet size and the received data PID against the expected one. It then reports whether the payload should be kept.

Tokens arrive one at a time with a pipe index. A separate pulse reports that the host acknowledged an IN data packet. All results are registered and appear one cycle after the token.

Top module: `ep_handshake_sel`

## Requirements
- R1: With response code 00 (force-NAK) on the addressed pipe, every valid token kind gets NAK (rsp_code 0) and the sequence bit does not change.
- R2: With response code 01 (buffer-driven), the replies are as follows. An IN token (tok_kind 1) gets data (rsp_code 4) when buf_ready is 1 and NAK otherwise. A PING token (tok_kind 2) gets ACK (rsp_code 1) when buf_ready is 1 and NAK otherwise. An OUT token (tok_kind 0) gets NAK when buf_ready is 0.
- R3: Response codes 10 and 11 give STALL (rsp_code 3) with no sequence change. A pipe index at or above NUM_PIPES also gives STALL, with rsp_data1 at 0 and no state change.
- R4: An OUT packet that is accepted under code 01 returns ACK when the pipe's ack-only bit is 1. When that bit is 0, it returns NYET (rsp_code 2) if buf_room is 0 and ACK if buf_room is 1. IN and PING tokens never get NYET.
- R5: A pulse on seq_clr[i] makes the next data PID of pipe i DATA0. This holds even if a toggle event for that pipe occurs in the same cycle.
- R6: After reset every pipe expects DATA0. An accepted OUT packet flips the pipe's bit. A host acknowledge pulse for an IN packet flips it, except in the case of R7.
- R7: On interrupt pipes (the bits set in INTR_MASK) with the free-running bit set, the bit flips when the data packet is sent, and host acknowledges have no effect. On bulk pipes the free-running bit is ignored.
- R8: An OUT packet under code 01 with buf_ready 1 and rx_len greater than the pipe's maximum packet size gets STALL, with rsp_size_err 1, rsp_keep 0 and no toggle. A length equal to the maximum is accepted.
- R9: An OUT packet whose rx_data1 differs from the expected sequence bit gets ACK, with rsp_seq_err 1, rsp_keep 0 and no toggle.
- R10: rsp_valid is 1 exactly in the cycle after tok_valid. rsp_data1 shows the pipe's sequence bit before that token's update. Token kind 3 is reserved and gets NAK with no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_resp | input | 2*NUM_PIPES | Response code per pipe, pipe i at bits [2i+1:2i] |
| cfg_ack_only | input | NUM_PIPES | 1 disables NYET replies for the pipe |
| cfg_free_run | input | NUM_PIPES | Free-running toggle on interrupt pipes |
| cfg_maxpkt | input | LEN_W*NUM_PIPES | Maximum packet size per pipe |
| seq_clr | input | NUM_PIPES | Sequence clear pulses |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_pipe | input | PIPE_W | Addressed pipe |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 PING, 3 reserved |
| buf_ready | input | 1 | Pipe buffer can accept or supply a packet |
| buf_room | input | 1 | Room for a further packet after this one |
| rx_data1 | input | 1 | Received data PID is DATA1 |
| rx_len | input | LEN_W | Received payload length |
| in_ack_valid | input | 1 | Host acknowledged an IN data packet |
| in_ack_pipe | input | PIPE_W | Pipe of that acknowledge |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 3 | 0 NAK, 1 ACK, 2 NYET, 3 STALL, 4 send data |
| rsp_data1 | output | 1 | Sequence bit of the pipe before update |
| rsp_size_err | output | 1 | Received length above maximum |
| rsp_seq_err | output | 1 | Data PID mismatch, payload discarded |
| rsp_keep | output | 1 | Payload accepted |

## Verification
The bench sweeps every pipe index, including the two beyond the pipe count, against every response code, token kind, buffer and room state, ack-only and free-running setting. It also covers matching and mismatching PIDs and lengths of zero, exactly the maximum, and one above. A design that let force-NAK lose to buffer state, offered NYET to PING, or compared size with greater-or-equal would return the wrong code at one of these points. Sequence bits are tracked through host acknowledges. A design that toggled on a mismatched or oversized packet, honoured free-running on a bulk pipe, or let a toggle beat a same-cycle clear would report the wrong data PID on a later token.

// File: rtl/hs_sel_pkg.sv
package hs_sel_pkg;

   typedef enum logic [2:0] {
      HS_NAK   = 3'd0,
      HS_ACK   = 3'd1,
      HS_NYET  = 3'd2,
      HS_STALL = 3'd3,
      HS_DATA  = 3'd4
   } hs_code_e;

   typedef enum logic [1:0] {
      TK_OUT  = 2'd0,
      TK_IN   = 2'd1,
      TK_PING = 2'd2,
      TK_RSVD = 2'd3
   } tok_kind_e;

   localparam logic [1:0] RC_FORCE_NAK = 2'b00;
   localparam logic [1:0] RC_BUFFER    = 2'b01;

   typedef struct packed {
      hs_code_e code;
      logic     size_err;
      logic     seq_err;
      logic     keep;
      logic     tgl;
   } hs_verdict_t;

endpackage

// File: rtl/hs_size_chk.sv
module hs_size_chk #(
   parameter int LEN_W  = 11,
   parameter bit ENABLE = 1'b1
) (
   input  logic [LEN_W-1:0] rx_len,
   input  logic [LEN_W-1:0] max_len,
   output logic             too_long
);

   generate
      if (ENABLE) begin : g_cmp
         assign too_long = (rx_len > max_len);
      end else begin : g_off
         assign too_long = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/hs_decide.sv
module hs_decide
   import hs_sel_pkg::*;
#(
   parameter int LEN_W      = 11,
   parameter bit SIZE_CHECK = 1'b1
) (
   input  logic              pipe_ok,
   input  logic [1:0]        resp_code,
   input  tok_kind_e         kind,
   input  logic              buf_rdy,
   input  logic              buf_next,
   input  logic              ack_only,
   input  logic              seq_bit,
   input  logic              rx_data1,
   input  logic [LEN_W-1:0]  rx_len,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              is_intr,
   input  logic              free_run,
   output hs_verdict_t       verdict
);

   logic too_long;

   hs_size_chk #(.LEN_W(LEN_W), .ENABLE(SIZE_CHECK)) i_size (
      .rx_len  (rx_len),
      .max_len (max_len),
      .too_long(too_long)
   );

   always_comb begin
      verdict = '{code: HS_NAK, size_err: 1'b0, seq_err: 1'b0, keep: 1'b0, tgl: 1'b0};
      if (!pipe_ok) begin
         verdict.code = HS_STALL;
      end else if (kind == TK_RSVD) begin
         verdict.code = HS_NAK;
      end else if (resp_code[1]) begin
         verdict.code = HS_STALL;
      end else if (resp_code == RC_FORCE_NAK) begin
         verdict.code = HS_NAK;
      end else begin
         unique case (kind)
            TK_IN: begin
               if (buf_rdy) begin
                  verdict.code = HS_DATA;
                  verdict.tgl  = is_intr & free_run;
               end
            end
            TK_PING: begin
               verdict.code = buf_rdy ? HS_ACK : HS_NAK;
            end
            TK_OUT: begin
               if (!buf_rdy) begin
                  verdict.code = HS_NAK;
               end else if (too_long) begin
                  verdict.code     = HS_STALL;
                  verdict.size_err = 1'b1;
               end else if (rx_data1 != seq_bit) begin
                  verdict.code    = HS_ACK;
                  verdict.seq_err = 1'b1;
               end else begin
                  verdict.keep = 1'b1;
                  verdict.tgl  = 1'b1;
                  verdict.code = (!ack_only && !buf_next) ? HS_NYET : HS_ACK;
               end
            end
            default: verdict.code = HS_NAK;
         endcase
      end
   end

endmodule

// File: rtl/hs_seq_bank.sv
module hs_seq_bank #(
   parameter int NUM_PIPES = 6,
   parameter int PIPE_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PIPES-1:0] clr,
   input  logic                 tok_tgl,
   input  logic [PIPE_W-1:0]    tok_pipe,
   input  logic                 ack_tgl,
   input  logic [PIPE_W-1:0]    ack_pipe,
   output logic [NUM_PIPES-1:0] seq_q
);

   generate
      for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
         localparam logic [PIPE_W-1:0] IDX = PIPE_W'(i);
         logic hit_t;
         logic hit_a;

         assign hit_t = tok_tgl && (tok_pipe == IDX);
         assign hit_a = ack_tgl && (ack_pipe == IDX);

         always_ff @(posedge clk) begin
            if (!rst_n)      seq_q[i] <= 1'b0;
            else if (clr[i]) seq_q[i] <= 1'b0;
            else             seq_q[i] <= seq_q[i] ^ hit_t ^ hit_a;
         end

         assert_seq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> !seq_q[i]);

         assert_seq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !hit_t && !hit_a) |=> $stable(seq_q[i]));

         assert_seq_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && (hit_t ^ hit_a)) |=> (seq_q[i] != $past(seq_q[i])));
      end
   endgenerate

endmodule

// File: rtl/ep_handshake_sel.sv
module ep_handshake_sel
   import hs_sel_pkg::*;
#(
   parameter int                   NUM_PIPES  = 6,
   parameter int                   MAX_LEN    = 1024,
   parameter logic [NUM_PIPES-1:0] INTR_MASK  = 6'b110000,
   parameter bit                   SIZE_CHECK = 1'b1,
   localparam int PIPE_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1,
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2*NUM_PIPES-1:0]       cfg_resp,
   input  logic [NUM_PIPES-1:0]         cfg_ack_only,
   input  logic [NUM_PIPES-1:0]         cfg_free_run,
   input  logic [LEN_W*NUM_PIPES-1:0]   cfg_maxpkt,
   input  logic [NUM_PIPES-1:0]         seq_clr,
   input  logic                         tok_valid,
   input  logic [PIPE_W-1:0]            tok_pipe,
   input  logic [1:0]                   tok_kind,
   input  logic                         buf_ready,
   input  logic                         buf_room,
   input  logic                         rx_data1,
   input  logic [LEN_W-1:0]             rx_len,
   input  logic                         in_ack_valid,
   input  logic [PIPE_W-1:0]            in_ack_pipe,
   output logic                         rsp_valid,
   output logic [2:0]                   rsp_code,
   output logic                         rsp_data1,
   output logic                         rsp_size_err,
   output logic                         rsp_seq_err,
   output logic                         rsp_keep
);

   localparam logic [PIPE_W:0] NP_W = (PIPE_W + 1)'(NUM_PIPES);

   generate
      if (NUM_PIPES < 1 || NUM_PIPES > 64) begin : g_bad_pipes
         $error("ep_handshake_sel: NUM_PIPES must lie in 1..64");
      end
      if (MAX_LEN < 1) begin : g_bad_len
         $error("ep_handshake_sel: MAX_LEN must be positive");
      end
   endgenerate

   logic [1:0]       resp_a [NUM_PIPES];
   logic [LEN_W-1:0] max_a  [NUM_PIPES];

   generate
      for (genvar i = 0; i < NUM_PIPES; i++) begin : g_unpack
         assign resp_a[i] = cfg_resp[2*i +: 2];
         assign max_a[i]  = cfg_maxpkt[LEN_W*i +: LEN_W];
      end
   endgenerate

   logic [NUM_PIPES-1:0] seq_q;
   logic                 pipe_ok;
   logic [PIPE_W-1:0]    idx;
   logic [1:0]           sel_resp;
   logic                 sel_ack_only;
   logic                 sel_seq;
   tok_kind_e            kind;
   hs_verdict_t          verdict;

   assign pipe_ok      = ({1'b0, tok_pipe} < NP_W);
   assign idx          = pipe_ok ? tok_pipe : '0;
   assign sel_resp     = resp_a[idx];
   assign sel_ack_only = cfg_ack_only[idx];
   assign sel_seq      = pipe_ok & seq_q[idx];
   assign kind         = tok_kind_e'(tok_kind);

   hs_decide #(.LEN_W(LEN_W), .SIZE_CHECK(SIZE_CHECK)) i_decide (
      .pipe_ok  (pipe_ok),
      .resp_code(sel_resp),
      .kind     (kind),
      .buf_rdy  (buf_ready),
      .buf_next (buf_room),
      .ack_only (sel_ack_only),
      .seq_bit  (sel_seq),
      .rx_data1 (rx_data1),
      .rx_len   (rx_len),
      .max_len  (max_a[idx]),
      .is_intr  (INTR_MASK[idx]),
      .free_run (cfg_free_run[idx]),
      .verdict  (verdict)
   );

   logic              ack_ok;
   logic [PIPE_W-1:0] aidx;
   logic              ack_tgl;
   logic              tok_tgl;

   assign ack_ok  = ({1'b0, in_ack_pipe} < NP_W);
   assign aidx    = ack_ok ? in_ack_pipe : '0;
   assign ack_tgl = in_ack_valid && ack_ok && !(INTR_MASK[aidx] && cfg_free_run[aidx]);
   assign tok_tgl = tok_valid && verdict.tgl;

   hs_seq_bank #(.NUM_PIPES(NUM_PIPES), .PIPE_W(PIPE_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (seq_clr),
      .tok_tgl (tok_tgl),
      .tok_pipe(tok_pipe),
      .ack_tgl (ack_tgl),
      .ack_pipe(in_ack_pipe),
      .seq_q   (seq_q)
   );

   hs_code_e code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         code_q       <= HS_NAK;
         rsp_data1    <= 1'b0;
         rsp_size_err <= 1'b0;
         rsp_seq_err  <= 1'b0;
         rsp_keep     <= 1'b0;
      end else begin
         rsp_valid    <= tok_valid;
         code_q       <= tok_valid ? verdict.code : HS_NAK;
         rsp_data1    <= tok_valid & sel_seq;
         rsp_size_err <= tok_valid & verdict.size_err;
         rsp_seq_err  <= tok_valid & verdict.seq_err;
         rsp_keep     <= tok_valid & verdict.keep;
      end
   end

   assign rsp_code = code_q;

   assert_nak_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && pipe_ok && tok_kind != 2'd3 && sel_resp == 2'b00) |=> (rsp_code == HS_NAK));

   assert_stall_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && pipe_ok && tok_kind != 2'd3 && sel_resp[1]) |=> (rsp_code == HS_STALL));

   assert_stall_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && !pipe_ok) |=> (rsp_code == HS_STALL && !rsp_data1));

   assert_nyet_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && (tok_kind != 2'd0 || sel_ack_only)) |=> (rsp_code != HS_NYET));

   assert_size_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_size_err |-> (rsp_code == HS_STALL && !rsp_keep));

   assert_mismatch_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_seq_err |-> (rsp_code == HS_ACK && !rsp_keep));

   assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |=> rsp_valid);

   assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> !rsp_valid);

endmodule

// File: tb/test_ep_handshake_sel.sv
`timescale 1ns/1ps
module test_ep_handshake_sel;

   localparam int NP = 6;
   localparam int LW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2*NP-1:0] cfg_resp = '0;
   logic [NP-1:0] cfg_ack_only = '0;
   logic [NP-1:0] cfg_free_run = '0;
   logic [LW*NP-1:0] cfg_maxpkt;
   logic [NP-1:0] seq_clr = '0;
   logic          tok_valid = 1'b0;
   logic [2:0]    tok_pipe = '0;
   logic [1:0]    tok_kind = '0;
   logic          buf_ready = 1'b0;
   logic          buf_room = 1'b0;
   logic          rx_data1 = 1'b0;
   logic [LW-1:0] rx_len = '0;
   logic          in_ack_valid = 1'b0;
   logic [2:0]    in_ack_pipe = '0;
   logic          rsp_valid;
   logic [2:0]    rsp_code;
   logic          rsp_data1;
   logic          rsp_size_err;
   logic          rsp_seq_err;
   logic          rsp_keep;

   ep_handshake_sel i_ep_handshake_sel (
      .clk(clk), .rst_n(rst_n), .cfg_resp(cfg_resp), .cfg_ack_only(cfg_ack_only),
      .cfg_free_run(cfg_free_run), .cfg_maxpkt(cfg_maxpkt), .seq_clr(seq_clr),
      .tok_valid(tok_valid), .tok_pipe(tok_pipe), .tok_kind(tok_kind),
      .buf_ready(buf_ready), .buf_room(buf_room), .rx_data1(rx_data1), .rx_len(rx_len),
      .in_ack_valid(in_ack_valid), .in_ack_pipe(in_ack_pipe), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .rsp_data1(rsp_data1), .rsp_size_err(rsp_size_err),
      .rsp_seq_err(rsp_seq_err), .rsp_keep(rsp_keep)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit [NP-1:0] seq_m = '0;
   int rc_g = 0, ao_g = 0, fr_g = 0;

   function automatic int maxpkt(input int p);
      return 8 << p;
   endfunction

   function automatic bit is_intr(input int p);
      return p >= 4;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic set_cfg(input int rc, input int ao, input int fr);
      rc_g = rc; ao_g = ao; fr_g = fr;
      for (int i = 0; i < NP; i++) begin
         cfg_resp[2*i +: 2] = rc[1:0];
         cfg_ack_only[i]    = ao[0];
         cfg_free_run[i]    = fr[0];
      end
   endtask

   function automatic string tag_for(input int p, input int k);
      if (p >= NP || rc_g >= 2) return "R3";
      if (k == 3) return "R10";
      if (rc_g == 0) return "R1";
      if (k == 0) return "R4";
      return "R2";
   endfunction

   task automatic do_tok(input int p, input int k, input int rdy, input int nxt,
                         input int pm, input int len, input int clrmask);
      int ecode, esz, esq, ekeep, etgl, epid;
      bit sb;
      @(negedge clk);
      sb = (p < NP) ? seq_m[p] : 1'b0;
      tok_valid = 1'b1; tok_pipe = p[2:0]; tok_kind = k[1:0];
      buf_ready = rdy[0]; buf_room = nxt[0]; rx_len = len[LW-1:0];
      rx_data1 = pm[0] ? sb : !sb;
      seq_clr = clrmask[NP-1:0];
      ecode = 0; esz = 0; esq = 0; ekeep = 0; etgl = 0; epid = sb;
      if (p >= NP) ecode = 3;
      else if (k == 3) ecode = 0;
      else if (rc_g >= 2) ecode = 3;
      else if (rc_g == 0) ecode = 0;
      else if (k == 1) begin
         if (rdy != 0) begin ecode = 4; etgl = (is_intr(p) && fr_g != 0) ? 1 : 0; end
      end else if (k == 2) ecode = (rdy != 0) ? 1 : 0;
      else begin
         if (rdy == 0) ecode = 0;
         else if (len > maxpkt(p)) begin ecode = 3; esz = 1; end
         else if (pm == 0) begin ecode = 1; esq = 1; end
         else begin
            ekeep = 1; etgl = 1;
            ecode = (ao_g == 0 && nxt == 0) ? 2 : 1;
         end
      end
      @(negedge clk);
      tok_valid = 1'b0; seq_clr = '0;
      chk("R10", "rsp_valid", rsp_valid, 1);
      chk(tag_for(p, k), "rsp_code", rsp_code, ecode);
      chk("R6", "rsp_data1", rsp_data1, epid);
      chk("R8", "rsp_size_err", rsp_size_err, esz);
      chk("R9", "rsp_seq_err", rsp_seq_err, esq);
      chk("R9", "rsp_keep", rsp_keep, ekeep);
      for (int i = 0; i < NP; i++)
         if (clrmask[i]) seq_m[i] = 1'b0;
         else if (i == p && etgl != 0) seq_m[i] = ~seq_m[i];
   endtask

   task automatic host_ack(input int p, input int clrmask);
      @(negedge clk);
      in_ack_valid = 1'b1; in_ack_pipe = p[2:0]; seq_clr = clrmask[NP-1:0];
      @(negedge clk);
      in_ack_valid = 1'b0; seq_clr = '0;
      chk("R10", "rsp_valid idle", rsp_valid, 0);
      for (int i = 0; i < NP; i++)
         if (clrmask[i]) seq_m[i] = 1'b0;
         else if (i == p && !(is_intr(p) && fr_g != 0)) seq_m[i] = ~seq_m[i];
   endtask

   initial begin
      for (int i = 0; i < NP; i++) cfg_maxpkt[LW*i +: LW] = LW'(maxpkt(i));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "reset rsp_valid", rsp_valid, 0);
      chk("R10", "reset rsp_code", rsp_code, 0);
      set_cfg(1, 0, 0);
      for (int p = 0; p < NP; p++) do_tok(p, 2, 1, 1, 1, 0, 0); // R6 reset DATA0

      // Sweep: R1 R2 R3 R4 R6 R7 R8 R9 R10
      for (int fr = 0; fr < 2; fr++)
      for (int ao = 0; ao < 2; ao++)
      for (int rc = 0; rc < 4; rc++) begin
         set_cfg(rc, ao, fr);
         for (int p = 0; p < 8; p++)
         for (int k = 0; k < 4; k++)
         for (int rdy = 0; rdy < 2; rdy++)
         for (int nxt = 0; nxt < 2; nxt++)
         for (int pm = 0; pm < 2; pm++)
         for (int lc = 0; lc < 3; lc++) begin
            int mp;
            mp = (p < NP) ? maxpkt(p) : 8;
            do_tok(p, k, rdy, nxt, pm, (lc == 0) ? 0 : (lc == 1) ? mp : mp + 1, 0);
            if (k == 1 && pm == 1 && p < NP) host_ack(p, 0); // R7 on pipes 4,5
         end
      end

      // R5: clear, clear against host ack, clear against accepted OUT
      set_cfg(1, 1, 0);
      for (int p = 0; p < NP; p++) begin
         if (!seq_m[p]) do_tok(p, 0, 1, 1, 1, 0, 0);
         chk("R5", "model bit set", seq_m[p], 1);
         host_ack(p, 1 << p);
         do_tok(p, 2, 1, 1, 1, 0, 0);
         do_tok(p, 0, 1, 1, 1, 0, 0);
         do_tok(p, 0, 1, 1, 1, 0, 1 << p);
         do_tok(p, 2, 1, 1, 1, 0, 0);
         chk("R5", "after clear", seq_m[p], 0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule